// File: doc/BRIEF.md
# Frame-Tagged Transmit Byte Queue

This block sits between a processor write port and a serial frame transmitter. The processor pushes data bytes into a 64-entry queue, and the transmitter pops one entry per request. Every entry holds a data byte and two marker bits. One marker ends the frame normally after that byte. The other ends the frame with an abort. Several frames can wait in the queue back to back, and each one is delimited by the marker on its final byte.

Markers always land on the byte written most recently. A marker can be given together with that byte's write, or on a later cycle. After the end-of-frame marker is set on a byte, no later marker write changes that byte. If a marker write arrives after its byte has already left the queue, it has no effect, and a one-cycle late flag reports this.

The block reports the free space to the processor. A space flag is raised whenever the free space is at or above a programmable level. Writing into a full queue does not stall the writer and raises no error. Instead, the newest byte is replaced each time, so the lost bytes are missing from the frame.

Top module: `txq_tagged_fifo`

## Requirements
- R1: After reset, the queue is empty: `rd_empty`=1, `free_cnt`=64 and `tag_late`=0.
- R2: Bytes are read out in the order they were stored. When `rd_req`=1 and the queue is not empty, the head entry is removed at the clock edge. When the queue is empty, `rd_req` has no effect.
- R3: `free_cnt` always equals 64 minus the number of stored entries.
- R4: `space_irq` is 1 exactly when `free_cnt` >= `trig_lvl`, with `trig_lvl` treated as an unsigned 6-bit value.
- R5: Fullness is judged on the count at the start of the cycle. A write while the queue holds 64 entries replaces the data of the newest entry and keeps that entry's markers. The write does not change the count, and no indication is given.
- R6: A marker write (`tag_en`=1) in the same cycle as a write into a non-full queue gives the new byte `rd_fin`=`tag_fin` and `rd_abt`=`tag_abt`. A marker write without such a push ORs `tag_fin` and `tag_abt` into the newest entry.
- R7: Once an entry's end-of-frame bit is 1, later marker writes change neither of its marker bits.
- R8: A marker write without a push is ignored in three cases: the newest entry has already been popped, it is popped in the same cycle, or nothing has been written since reset. In each case `tag_late` is 1 for exactly the following cycle.
- R9: Markers stay with their own bytes across several queued frames. `rd_fin` and `rd_abt` show the markers of the head entry, alongside `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write a data byte |
| wr_data | input | 8 | Byte to write |
| tag_en | input | 1 | Apply marker bits |
| tag_fin | input | 1 | End-of-frame marker value |
| tag_abt | input | 1 | Abort marker value |
| rd_req | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data |
| rd_fin | output | 1 | Head entry end-of-frame marker |
| rd_abt | output | 1 | Head entry abort marker |
| rd_empty | output | 1 | Queue holds no entry |
| trig_lvl | input | 6 | Free-space threshold |
| free_cnt | output | 7 | Number of bytes that can still be written |
| space_irq | output | 1 | Free space at or above threshold |
| tag_late | output | 1 | Previous marker write was dropped as late |

## Verification
A wrong count shows up on `free_cnt` and `space_irq` in the cycle after the bad update. A mis-tracked newest-entry index shows up later. It stays hidden until an overrun or a marker write hits the wrong entry, and that entry then reaches the head with the wrong data or markers. This can happen up to 64 pops later. The bench therefore keeps a reference model and compares every output every cycle. It drives long fill, overrun and drain phases, so corrupted entries are always read out.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef struct packed {
      logic fin;
      logic abt;
   } tag_t;
endpackage

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
   parameter int DEPTH = 64,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_req,
   input  logic          tag_en,
   output logic          push,
   output logic          ovw,
   output logic          tag_ok,
   output logic [PW-1:0] wr_idx,
   output logic [PW-1:0] rd_idx,
   output logic [PW-1:0] last_idx,
   output logic [CW-1:0] cnt,
   output logic          tag_late
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] TOP_IDX  = PW'(DEPTH - 1);

   logic pop, full, last_live, last_gone;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == TOP_IDX) ? '0 : p + 1'b1;
   endfunction

   assign full      = (cnt == FULL_CNT);
   assign pop       = rd_req && (cnt != '0);
   assign push      = wr_en && !full;
   assign ovw       = wr_en && full;
   assign last_gone = pop && (rd_idx == last_idx);
   assign tag_ok    = tag_en && !push && last_live && !last_gone;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         rd_idx    <= '0;
         last_idx  <= '0;
         cnt       <= '0;
         last_live <= 1'b0;
         tag_late  <= 1'b0;
      end else begin
         tag_late <= tag_en && !push && !tag_ok;
         if (push) begin
            wr_idx    <= bump(wr_idx);
            last_idx  <= wr_idx;
            last_live <= 1'b1;
         end else if (last_gone) begin
            last_live <= 1'b0;
         end
         if (pop) rd_idx <= bump(rd_idx);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r5_overrun_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_req) |=> (cnt == FULL_CNT));
   a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !wr_en) |=> (cnt == '0));
   a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);
   a_r8_no_late_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> !tag_late);
endmodule

// File: rtl/txq_store.sv
module txq_store
   import txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              ovw,
   input  logic              tag_ok,
   input  logic [PW-1:0]     wr_idx,
   input  logic [PW-1:0]     last_idx,
   input  logic [PW-1:0]     rd_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  tag_t              tag_new,
   input  tag_t              tag_in,
   output logic [DATA_W-1:0] rd_data,
   output tag_t              rd_tag
);
   logic [DATA_W-1:0] data_q [DEPTH];
   tag_t              tag_q  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [PW-1:0] IDX = PW'(e);
      logic hit_push, hit_last;
      assign hit_push = push && (wr_idx == IDX);
      assign hit_last = last_idx == IDX;

      always_ff @(posedge clk) begin
         if (hit_push || (ovw && hit_last)) data_q[e] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tag_q[e] <= '0;
         else if (hit_push)
            tag_q[e] <= tag_new;
         else if (tag_ok && hit_last && !tag_q[e].fin)
            tag_q[e] <= tag_t'(tag_q[e] | tag_in);
      end

      a_r7_fin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_q[e].fin && !hit_push) |=> tag_q[e].fin);
      a_r7_abt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_q[e].fin && !hit_push) |=> $stable(tag_q[e].abt));
   end

   assign rd_data = data_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
endmodule

// File: rtl/txq_level.sv
module txq_level #(
   parameter int DEPTH   = 64,
   parameter bit REG_IRQ = 1'b0,
   localparam int LW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic [LW-1:0] trig_lvl,
   output logic [CW-1:0] free_cnt,
   output logic          space_irq
);
   logic above;

   assign free_cnt = CW'(DEPTH) - cnt;
   assign above    = free_cnt >= CW'(trig_lvl);

   if (REG_IRQ) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) space_irq <= 1'b0;
         else        space_irq <= above;
      end
   end else begin : g_comb
      assign space_irq = above;
      a_r4_irq_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_lvl == '0) |-> space_irq);
   end
endmodule

// File: rtl/txq_tagged_fifo.sv
module txq_tagged_fifo
   import txq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 64,
   parameter bit REG_IRQ = 1'b0,
   localparam int PW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tag_en,
   input  logic              tag_fin,
   input  logic              tag_abt,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_fin,
   output logic              rd_abt,
   output logic              rd_empty,
   input  logic [LW-1:0]     trig_lvl,
   output logic [CW-1:0]     free_cnt,
   output logic              space_irq,
   output logic              tag_late
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("txq_tagged_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("txq_tagged_fifo: DATA_W must be positive");
   end

   logic          push, ovw, tag_ok;
   logic [PW-1:0] wr_idx, rd_idx, last_idx;
   logic [CW-1:0] cnt;
   tag_t          tag_in, tag_new, rd_tag;

   assign tag_in  = '{fin: tag_fin, abt: tag_abt};
   assign tag_new = tag_en ? tag_in : '0;

   txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk, .rst_n, .wr_en, .rd_req, .tag_en,
      .push, .ovw, .tag_ok, .wr_idx, .rd_idx, .last_idx, .cnt, .tag_late
   );

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk, .rst_n, .push, .ovw, .tag_ok, .wr_idx, .last_idx, .rd_idx,
      .wr_data, .tag_new, .tag_in, .rd_data, .rd_tag
   );

   txq_level #(.DEPTH(DEPTH), .REG_IRQ(REG_IRQ)) u_level (
      .clk, .rst_n, .cnt, .trig_lvl, .free_cnt, .space_irq
   );

   assign rd_fin   = rd_tag.fin;
   assign rd_abt   = rd_tag.abt;
   assign rd_empty = (cnt == '0);

   a_r8_late_needs_tag: assert property (@(posedge clk) disable iff (!rst_n)
      tag_late |-> $past(tag_en));
   a_r2_pop_frees_space: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_empty && !wr_en) |=> (free_cnt == $past(free_cnt) + 1'b1));
endmodule

// File: tb/txq_tagged_fifo_tb.sv
module txq_tagged_fifo_tb;
   localparam int D = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, tag_en = 0, tag_fin = 0, tag_abt = 0, rd_req = 0;
   logic [7:0] wr_data = '0;
   logic [5:0] trig_lvl = '0;
   logic [7:0] rd_data;
   logic       rd_fin, rd_abt, rd_empty, space_irq, tag_late;
   logic [6:0] free_cnt;

   int nchk = 0, nfail = 0;
   bit done = 0;

   // reference model state
   logic [7:0] m_data [D];
   bit         m_fin [D], m_abt [D];
   int         m_head, m_tail, m_cnt, m_last;
   bit         m_live, m_late;

   always #4 clk = ~clk;

   txq_tagged_fifo u_dut (
      .clk, .rst_n, .wr_en, .wr_data, .tag_en, .tag_fin, .tag_abt, .rd_req,
      .rd_data, .rd_fin, .rd_abt, .rd_empty, .trig_lvl, .free_cnt,
      .space_irq, .tag_late
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_free();
      return D - m_cnt;
   endfunction

   function automatic int exp_irq(input int lvl);
      return (exp_free() >= lvl) ? 1 : 0;
   endfunction

   task automatic compare();
      chk("R3 free_cnt", int'(free_cnt), exp_free());
      chk("R4 space_irq", int'(space_irq), exp_irq(int'(trig_lvl)));
      chk("R2 rd_empty", int'(rd_empty), (m_cnt == 0) ? 1 : 0);
      chk("R8 tag_late", int'(tag_late), int'(m_late));
      if (m_cnt > 0) begin
         chk("R2/R5 rd_data", int'(rd_data), int'(m_data[m_head]));
         chk("R6/R9 rd_fin", int'(rd_fin), int'(m_fin[m_head]));
         chk("R6/R9 rd_abt", int'(rd_abt), int'(m_abt[m_head]));
      end
   endtask

   task automatic model_step();
      bit pop, push, ovw;
      bit late_n;
      pop    = rd_req && (m_cnt > 0);
      push   = wr_en && (m_cnt < D);
      ovw    = wr_en && (m_cnt == D);
      late_n = 0;
      if (push) begin
         m_data[m_tail] = wr_data;
         m_fin[m_tail]  = tag_en && tag_fin;
         m_abt[m_tail]  = tag_en && tag_abt;
      end
      if (ovw) m_data[m_last] = wr_data;
      if (tag_en && !push) begin
         if (m_live && !(pop && m_head == m_last)) begin
            if (!m_fin[m_last]) begin
               m_fin[m_last] = m_fin[m_last] | tag_fin;
               m_abt[m_last] = m_abt[m_last] | tag_abt;
            end
         end else begin
            late_n = 1;
         end
      end
      if (push) begin
         m_last = m_tail;
         m_live = 1;
      end else if (pop && m_head == m_last) begin
         m_live = 0;
      end
      if (push) begin
         m_tail = (m_tail + 1) % D;
         m_cnt++;
      end
      if (pop) begin
         m_head = (m_head + 1) % D;
         m_cnt--;
      end
      m_late = late_n;
   endtask

   // one cycle: check current outputs, drive new inputs, advance model
   task automatic cyc(input bit w, input logic [7:0] d, input bit t,
                      input bit tf, input bit ta, input bit r);
      @(negedge clk);
      compare();
      wr_en = w; wr_data = d; tag_en = t; tag_fin = tf; tag_abt = ta; rd_req = r;
      model_step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      m_head = 0; m_tail = 0; m_cnt = 0; m_last = 0; m_live = 0; m_late = 0;
      for (int i = 0; i < D; i++) begin
         m_fin[i] = 0; m_abt[i] = 0; m_data[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_empty", int'(rd_empty), 1);
      chk("R1 free_cnt", int'(free_cnt), 64);
      chk("R1 tag_late", int'(tag_late), 0);

      // R8: marker before any write is late
      cyc(0, 8'h00, 1, 1, 0, 0);
      cyc(0, 8'h00, 0, 0, 0, 0);
      chk("R8 late pulse after empty tag", int'(tag_late), 1);
      cyc(0, 8'h00, 0, 0, 0, 0);

      // R2: pop on empty ignored
      cyc(0, 8'h00, 0, 0, 0, 1);
      cyc(0, 8'h00, 0, 0, 0, 0);

      // R4/R5: fill to full with threshold 63, then overrun
      trig_lvl = 6'd63;
      for (int i = 0; i < D; i++) cyc(1, 8'(i + 8'h40), 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 8'(8'hA0 + i), 0, 0, 0, 0);
      cyc(0, 8'h00, 1, 1, 0, 0);          // R6 end-of-frame on newest
      cyc(0, 8'h00, 1, 0, 1, 0);          // R7 abort must be ignored
      cyc(1, 8'hEE, 0, 0, 0, 0);          // R5 overrun keeps markers
      cyc(0, 8'h00, 0, 0, 0, 0);
      chk("R5 free_cnt at full", int'(free_cnt), 0);
      chk("R4 irq low at full", int'(space_irq), 0);
      trig_lvl = 6'd0;
      for (int i = 0; i < D + 2; i++) cyc(0, 8'h00, 0, 0, 0, 1);
      cyc(0, 8'h00, 0, 0, 0, 0);

      // R8: pop the newest byte, then tag it (late); tag same cycle as pop
      cyc(1, 8'h11, 0, 0, 0, 0);
      cyc(0, 8'h00, 0, 0, 0, 1);
      cyc(0, 8'h00, 1, 1, 0, 0);
      cyc(1, 8'h22, 0, 0, 0, 0);
      cyc(0, 8'h00, 1, 0, 1, 1);
      cyc(0, 8'h00, 0, 0, 0, 0);

      // R9: back-to-back frames, including one-byte frames
      cyc(1, 8'h31, 1, 1, 0, 0);
      cyc(1, 8'h32, 0, 0, 0, 0);
      cyc(1, 8'h33, 1, 0, 1, 0);
      cyc(1, 8'h34, 0, 0, 0, 0);
      cyc(0, 8'h00, 1, 1, 0, 0);
      for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0, 0, 0, 1);

      // random phases: fill-heavy, balanced, drain-heavy
      for (int ph = 0; ph < 12; ph++) begin
         int pw, pr, pt;
         pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 50 : 20;
         pr = (ph % 3 == 2) ? 85 : (ph % 3 == 1) ? 50 : 20;
         pt = 25;
         trig_lvl = 6'($urandom_range(0, 63));
         for (int k = 0; k < 500; k++) begin
            cyc(($urandom_range(0, 99) < pw), 8'($urandom),
                ($urandom_range(0, 99) < pt), 1'($urandom), 1'($urandom),
                ($urandom_range(0, 99) < pr));
         end
      end
      cyc(0, 8'h00, 0, 0, 0, 0);
      cyc(0, 8'h00, 0, 0, 0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule